// File: doc/BRIEF.md
# Vector Register Half-Move Unit

This block is a small vector register file with a permutation engine. Each register holds MVL elements. Besides a plain register-to-register copy, the engine has two one-way moves. Half-move-up writes the source's low blocks into the destination's high blocks. Half-move-down writes the source's high blocks into the destination's low blocks. In both moves the other half of the destination keeps its value, and the source is never modified.

A block size of 2^k elements splits a register into interleaved low and high blocks. Element i lies in a high block when bit k of its index is 1. To exchange blocks between registers A and B:

1. Copy A into a scratch register.
2. Half-move-up from B into A.
3. Half-move-down from the scratch register into B.

Repeating this with k = log2(MVL)-1 down to 0 gives the later FFT stages the data ordering they need. Every vector operation then still runs at full vector length.

A command is taken in a single cycle. Its result is written at the next clock edge, and `done` pulses in the cycle after the command. Illegal commands are refused and flagged on `err`. An external port writes whole registers, and a combinational read port returns any register.

Top module: `vec_halfmove_unit`

## Requirements
- R1: While `rst` is high, all registers clear to zero and `done` and `err` are low.
- R2: Opcode 0 (copy) makes the destination register equal to the source register after the next clock edge.
- R3: Opcode 1 (half-move-up) with `cmd_lgb` = k sets dst[i] = src[i - 2^k] for every i whose index bit k is 1. It leaves the elements whose bit k is 0 unchanged.
- R4: Opcode 2 (half-move-down) with `cmd_lgb` = k sets dst[i] = src[i + 2^k] for every i whose index bit k is 0. It leaves the elements whose bit k is 1 unchanged.
- R5: A command never changes its source register, unless that register is the target of an external write in the same cycle.
- R6: `done` is high in exactly the cycles that directly follow a cycle with `cmd_valid` high.
- R7: A command is refused in three cases: source equals destination, opcode is 3, or a move opcode has `cmd_lgb` of log2(MVL) or more. A refused command raises `err` together with `done` and changes no register.
- R8: `wr_en` writes `wr_data` into register `wr_addr` at the clock edge. If an accepted command targets the same register in the same cycle, the command's result is written instead.
- R9: `rd_data` shows register `rd_addr` combinationally. Element i occupies bits [i*EW +: EW].
- R10: With MVL = 8, registers holding 0..7 and 8..15 are swapped with block size 4, then 2. This gives 0,1,2,3,8,9,10,11 and 4,5,6,7,12,13,14,15, and then 0,1,4,5,8,9,12,13 and 2,3,6,7,10,11,14,15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 copy, 1 half-move-up, 2 half-move-down, 3 reserved |
| cmd_src | input | AW | Source register index |
| cmd_dst | input | AW | Destination register index |
| cmd_lgb | input | LGW | log2 of the block size |
| wr_en | input | 1 | External whole-register write enable |
| wr_addr | input | AW | External write register index |
| wr_data | input | MVL*EW | External write vector |
| rd_addr | input | AW | Read register index |
| rd_data | output | MVL*EW | Read vector |
| done | output | 1 | Command finished (one cycle after it) |
| err | output | 1 | Command refused (with done) |

## Verification
A wrong partner index or a wrong high/low selection changes specific elements of the destination. The read port shows this in the cycle right after the command, and the bench reads every register in that cycle. A corrupted source or a write leaking into another register shows up in the same way, in the same cycle. A bad acceptance decision shows as a wrong `err`, or as a change where none was expected, one cycle after the command.

// File: rtl/vhm_pkg.sv
package vhm_pkg;
    localparam int NREG    = 4;
    localparam int MVL     = 8;
    localparam int EW      = 16;
    localparam int LOG_MVL = $clog2(MVL);
    localparam int AW      = $clog2(NREG);
    localparam int LGW     = $clog2(LOG_MVL) + 1;
    localparam int VW      = MVL * EW;

    typedef enum logic [1:0] {
        OP_COPY = 2'd0,
        OP_HUP  = 2'd1,
        OP_HDN  = 2'd2,
        OP_RSV  = 2'd3
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [LGW-1:0]  lgb;
    } cmd_t;

    // Partner of element idx at block size 2^lgb (index bit lgb flipped).
    function automatic logic [LOG_MVL-1:0] partner_of(input int unsigned idx,
                                                      input logic [LGW-1:0] lgb);
        logic [LOG_MVL-1:0] sel;
        sel = LOG_MVL'(1) << lgb;
        return LOG_MVL'(idx) ^ sel;
    endfunction

    function automatic logic in_high(input int unsigned idx,
                                     input logic [LGW-1:0] lgb);
        logic [LOG_MVL-1:0] sel;
        sel = LOG_MVL'(1) << lgb;
        return (LOG_MVL'(idx) & sel) != '0;
    endfunction
endpackage

// File: rtl/vhm_decode.sv
module vhm_decode
    import vhm_pkg::*;
(
    input  logic cmd_valid,
    input  cmd_t cmd,
    output logic accept,
    output logic reject
);
    logic size_ok;
    logic legal;

    always_comb begin
        size_ok = (cmd.op == OP_COPY) || (cmd.lgb < LGW'(LOG_MVL));
        legal   = (cmd.src != cmd.dst) && (cmd.op != OP_RSV) && size_ok;
        accept  = cmd_valid && legal;
        reject  = cmd_valid && !legal;
    end
endmodule

// File: rtl/vhm_permute.sv
module vhm_permute
    import vhm_pkg::*;
(
    input  logic [VW-1:0]  src_vec,
    input  logic [VW-1:0]  dst_vec,
    input  op_e            op,
    input  logic [LGW-1:0] lgb,
    output logic [VW-1:0]  res_vec
);
    for (genvar gi = 0; gi < MVL; gi++) begin : g_elem
        logic [LOG_MVL-1:0] pidx;
        logic               hi;
        logic [EW-1:0]      own_src;
        logic [EW-1:0]      own_dst;
        logic [EW-1:0]      far_src;

        always_comb begin
            pidx    = partner_of(gi, lgb);
            hi      = in_high(gi, lgb);
            own_src = src_vec[gi*EW +: EW];
            own_dst = dst_vec[gi*EW +: EW];
            far_src = src_vec[pidx*EW +: EW];
            unique case (op)
                OP_COPY: res_vec[gi*EW +: EW] = own_src;
                OP_HUP:  res_vec[gi*EW +: EW] = hi  ? far_src : own_dst;
                OP_HDN:  res_vec[gi*EW +: EW] = !hi ? far_src : own_dst;
                default: res_vec[gi*EW +: EW] = own_dst;
            endcase
        end
    end
endmodule

// File: rtl/vhm_regfile.sv
module vhm_regfile
    import vhm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_we,
    input  logic [AW-1:0]      ext_addr,
    input  logic [VW-1:0]      ext_data,
    input  logic               cmd_we,
    input  logic [AW-1:0]      cmd_addr,
    input  logic [VW-1:0]      cmd_data,
    input  logic [AW-1:0]      ra_addr,
    output logic [VW-1:0]      ra_data,
    input  logic [AW-1:0]      rs_addr,
    output logic [VW-1:0]      rs_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [VW-1:0]      rd_data,
    output logic [NREG*VW-1:0] all_q
);
    logic [VW-1:0] regs [NREG];

    for (genvar gr = 0; gr < NREG; gr++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[gr] <= '0;
            else if (cmd_we && cmd_addr == AW'(gr))
                regs[gr] <= cmd_data;
            else if (ext_we && ext_addr == AW'(gr))
                regs[gr] <= ext_data;
        end
        assign all_q[gr*VW +: VW] = regs[gr];
    end

    assign ra_data = regs[ra_addr];
    assign rs_data = regs[rs_addr];
    assign rd_data = regs[rd_addr];
endmodule

// File: rtl/vec_halfmove_unit.sv
module vec_halfmove_unit
    import vhm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [AW-1:0]    cmd_src,
    input  logic [AW-1:0]    cmd_dst,
    input  logic [LGW-1:0]   cmd_lgb,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [VW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [VW-1:0]    rd_data,
    output logic             done,
    output logic             err
);
    cmd_t               cmd;
    logic               accept;
    logic               reject;
    logic [VW-1:0]      src_vec;
    logic [VW-1:0]      dst_vec;
    logic [VW-1:0]      res_vec;
    logic [NREG*VW-1:0] rf_flat;

    assign cmd = '{op: op_e'(cmd_op), src: cmd_src, dst: cmd_dst, lgb: cmd_lgb};

    vhm_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .accept    (accept),
        .reject    (reject)
    );

    vhm_permute u_perm (
        .src_vec (src_vec),
        .dst_vec (dst_vec),
        .op      (cmd.op),
        .lgb     (cmd.lgb),
        .res_vec (res_vec)
    );

    vhm_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .ext_we   (wr_en),
        .ext_addr (wr_addr),
        .ext_data (wr_data),
        .cmd_we   (accept),
        .cmd_addr (cmd.dst),
        .cmd_data (res_vec),
        .ra_addr  (cmd.src),
        .ra_data  (src_vec),
        .rs_addr  (cmd.dst),
        .rs_data  (dst_vec),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .all_q    (rf_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= cmd_valid;
            err  <= reject;
        end
    end
endmodule

// File: rtl/vhm_chk.sv
module vhm_chk
    import vhm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic [AW-1:0]      cmd_src,
    input logic               wr_en,
    input logic [AW-1:0]      wr_addr,
    input logic               done,
    input logic               err,
    input logic [NREG*VW-1:0] rf_flat
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (rf_flat == '0 && !done && !err));

    // R6
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !done);

    // R7
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R7
    reject_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!wr_en) && err) |-> (rf_flat == $past(rf_flat)));

    // R5
    source_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !(wr_en && wr_addr == cmd_src)) |=>
        (rf_flat[$past(cmd_src)*VW +: VW] == $past(rf_flat[cmd_src*VW +: VW])));
endmodule

bind vec_halfmove_unit vhm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_src   (cmd_src),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .done      (done),
    .err       (err),
    .rf_flat   (rf_flat)
);

// File: tb/sim_vec_halfmove_unit.sv
module sim_vec_halfmove_unit;
    import vhm_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [AW-1:0]    cmd_src;
    logic [AW-1:0]    cmd_dst;
    logic [LGW-1:0]   cmd_lgb;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [VW-1:0]    wr_data;
    logic [AW-1:0]    rd_addr;
    logic [VW-1:0]    rd_data;
    logic             done;
    logic             err;

    int n_tests = 0;
    int n_fail  = 0;

    logic [EW-1:0] mdl [NREG][MVL];
    logic          exp_done;
    logic          exp_err;

    vec_halfmove_unit u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_lgb(cmd_lgb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .err(err)
    );

    function automatic logic [VW-1:0] pack_reg(input int r);
        logic [VW-1:0] v;
        for (int i = 0; i < MVL; i++) v[i*EW +: EW] = mdl[r][i];
        return v;
    endfunction

    function automatic logic [VW-1:0] seq_vec(input int base);
        logic [VW-1:0] v;
        for (int i = 0; i < MVL; i++) v[i*EW +: EW] = EW'(base + i);
        return v;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < MVL; i++) v[i*EW +: EW] = EW'($urandom);
        return v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "done", VW'(done), VW'(exp_done));
        chk(req, "err", VW'(err), VW'(exp_err));
        for (int r = 0; r < NREG; r++) begin
            rd_addr = AW'(r);
            #1;
            chk(req, $sformatf("reg%0d", r), rd_data, pack_reg(r));
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus and checks.
    task automatic step(input logic v, input int op, input int s, input int d,
                        input int lg, input logic we, input int wa,
                        input logic [VW-1:0] wd, input string req);
        logic [EW-1:0] tmp [MVL];
        logic          legal;
        int            bs;
        cmd_valid = v;  cmd_op = 2'(op); cmd_src = AW'(s); cmd_dst = AW'(d);
        cmd_lgb = LGW'(lg);  wr_en = we;  wr_addr = AW'(wa);  wr_data = wd;
        legal = (s != d) && (op != 3) && (op == 0 || lg < LOG_MVL);
        bs = 1 << (lg < LOG_MVL ? lg : 0);
        for (int i = 0; i < MVL; i++) begin
            tmp[i] = mdl[d][i];
            if (op == 0) tmp[i] = mdl[s][i];
            else if (op == 1 && ((i / bs) % 2) == 1) tmp[i] = mdl[s][i - bs];
            else if (op == 2 && ((i / bs) % 2) == 0) tmp[i] = mdl[s][i + bs];
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        wr_en = 1'b0;
        if (we) for (int i = 0; i < MVL; i++) mdl[wa][i] = wd[i*EW +: EW];
        if (v && legal) for (int i = 0; i < MVL; i++) mdl[d][i] = tmp[i];
        exp_done = v;
        exp_err  = v && !legal;
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_src = '0; cmd_dst = '0;
        cmd_lgb = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        for (int r = 0; r < NREG; r++)
            for (int i = 0; i < MVL; i++) mdl[r][i] = '0;
        exp_done = 1'b0;
        exp_err  = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R8 / R9: load via the write port, read back combinationally
        step(0, 0, 0, 0, 0, 1, 0, seq_vec(0), "R8");
        step(0, 0, 0, 0, 0, 1, 1, seq_vec(MVL), "R9");

        // R10 swap sequence, block size halves each stage
        for (int lg = LOG_MVL - 1; lg >= 0; lg--) begin
            step(1, 0, 0, 3, 0, 0, 0, '0, "R2");
            step(1, 1, 1, 0, lg, 0, 0, '0, "R3");
            step(1, 2, 3, 1, lg, 0, 0, '0, "R4");
            if (MVL == 8 && lg == 2) begin
                rd_addr = 0; #1;
                chk("R10", "stage lg2 A", rd_data,
                    {16'd11,16'd10,16'd9,16'd8,16'd3,16'd2,16'd1,16'd0});
                rd_addr = 1; #1;
                chk("R10", "stage lg2 B", rd_data,
                    {16'd15,16'd14,16'd13,16'd12,16'd7,16'd6,16'd5,16'd4});
            end
            if (MVL == 8 && lg == 1) begin
                rd_addr = 0; #1;
                chk("R10", "stage lg1 A", rd_data,
                    {16'd13,16'd12,16'd9,16'd8,16'd5,16'd4,16'd1,16'd0});
                rd_addr = 1; #1;
                chk("R10", "stage lg1 B", rd_data,
                    {16'd15,16'd14,16'd11,16'd10,16'd7,16'd6,16'd3,16'd2});
            end
        end

        // R7: refused commands
        step(1, 1, 2, 2, 0, 0, 0, '0, "R7");
        step(1, 2, 0, 1, LOG_MVL, 0, 0, '0, "R7");
        step(1, 3, 0, 1, 0, 0, 0, '0, "R7");
        step(1, 0, 1, 1, 0, 0, 0, '0, "R7");

        // R8: collision on the destination, command wins
        step(1, 0, 0, 2, 0, 1, 2, rand_vec(), "R8");
        // R5: write to another register alongside a command
        step(1, 1, 0, 2, 0, 1, 3, rand_vec(), "R5");
        // R6: idle cycle
        step(0, 1, 0, 2, 0, 0, 0, '0, "R6");

        // Mixed patterns against the model
        for (int k = 0; k < 400; k++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 3),
                 $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1),
                 $urandom_range(0, LOG_MVL), $urandom_range(0, 2) == 0,
                 $urandom_range(0, NREG - 1), rand_vec(), "R3/R4");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule